// File: doc/BRIEF.md
# Counting Decimator Array with Serial Snapshot Readout

This block turns the single-bit streams of sixteen first-order delta-sigma modulators into sixteen 16-bit conversion results. A shared timing unit divides the system clock into a gain strobe that fires once every `gain_div` system cycles. It also groups `osr_len` strobes into one conversion period. On each strobe, every channel adds its modulator bit to a private counter. At the last strobe of a period, the count, including that strobe's bit, is moved to the channel's result register and the counter starts again from zero.

A readout side on its own clock can take a snapshot of all sixteen result registers at any moment, whether or not a conversion is in progress. A request toggle crosses into the system domain through two flops, the system side copies the results into a hold bank, and an acknowledge toggle returns through two flops. The readout side then loads a 256-bit shift register from the hold bank. Because the hold bank stays still while the acknowledge is in flight, a word is never split across a result update. The stream leaves one bit per shift cycle.

Top module: `cnt_decim_array`

## Requirements
- R1: The gain strobe fires exactly once every `gain_div` system cycles, starting from reset; a `gain_div` of 0 behaves as 1.
- R2: A channel counter only changes on a strobe cycle, and then adds that channel's `mod_bits` bit (value 1 counts, value 0 does not).
- R3: On the `osr_len`-th strobe of a conversion (0 treated as 1), the result register takes the count including that strobe's bit, and the counter restarts at zero.
- R4: A counter that reaches 65535 stays at 65535 until the conversion ends; it never wraps.
- R5: A result register holds its value between conversion ends, so a snapshot taken mid-conversion returns the last completed result.
- R6: A `rd_load` seen on a rising `rd_clk` edge while `rd_busy` is low raises `rd_busy` on that edge. `rd_busy` stays high until the snapshot sits in the shift register, and the captured words stay still in the meantime.
- R7: A `rd_load` while `rd_busy` is high is ignored: no second snapshot is started and `rd_busy` stays low once the first completes.
- R8: After a snapshot, `ser_out` shows channel 0 first, MSB first within each word, followed by channels 1 to 15. Each `rd_clk` edge with `rd_shift` high advances one bit, and after 256 shifts `ser_out` is 0.
- R9: After reset, `rd_busy` and `ser_out` are 0 and all results read back as zero.
- R10: A new snapshot after a partial shift-out restarts the stream at channel 0, MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for modulator sampling and counting |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| gain_div | input | GAIN_W | Strobe period in system cycles (0 acts as 1) |
| osr_len | input | OSR_W | Strobes per conversion (0 acts as 1) |
| mod_bits | input | NUM_CH | One modulator bit per channel, sampled on strobe cycles |
| rd_clk | input | 1 | Readout clock, unrelated to `sys_clk` |
| rd_rst_n | input | 1 | Synchronous active-low reset, readout domain |
| rd_load | input | 1 | Request a snapshot of all results |
| rd_shift | input | 1 | Advance the serial stream by one bit |
| rd_busy | output | 1 | Snapshot request in flight |
| ser_out | output | 1 | Current serial bit |

## Verification
The assertions check on every cycle that the strobe never fires on two cycles in a row when the period exceeds one, and that counters move only on strobes and hold at full scale. They also check that counters clear right after a dump, that results change only at a conversion end, that the hold bank stays put while no request is pending, and that no request is raised while one is busy. The order of the serial stream, the exact counts for various periods and bit patterns, saturation after more than 65535 strobes, the ignored second load and the restart after a partial read can only be shown by the bench. Its scenarios compare every shifted word against a reference model that runs cycle by cycle.

// File: rtl/decim_pkg.sv
// Package: shared constants and helpers for the counting decimator array.
// Assumes period and index values fit within 32 bits.
package decim_pkg;
    localparam int unsigned DEF_NUM_CH = 16;
    localparam int unsigned DEF_CNT_W  = 16;

    // True when index idx is the last one of a period of length lim (0 acts as 1).
    function automatic logic last_of(input logic [31:0] idx, input logic [31:0] lim);
        return ({1'b0, idx} + 33'd1) >= {1'b0, lim};
    endfunction
endpackage

// File: rtl/decim_timing.sv
// decim_timing: derives the gain strobe and the end-of-conversion pulse
// from the system clock. Assumes gain_div and osr_len change only in reset.
module decim_timing
    import decim_pkg::*;
#(
    parameter int unsigned GAIN_W = 8,
    parameter int unsigned OSR_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain_div,
    input  logic [OSR_W-1:0]  osr_len,
    output logic              stb,
    output logic              conv_end
);
    logic [GAIN_W-1:0] gcnt;
    logic [OSR_W-1:0]  ocnt;

    // Strobe and conversion end decode from the phase counters.
    always_comb begin
        stb      = last_of(32'(gcnt), 32'(gain_div));
        conv_end = stb && last_of(32'(ocnt), 32'(osr_len));
    end

    // Phase within one strobe period.
    always_ff @(posedge clk) begin
        if (!rst_n)   gcnt <= '0;
        else if (stb) gcnt <= '0;
        else          gcnt <= gcnt + 1'b1;
    end

    // Strobe index within one conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)        ocnt <= '0;
        else if (conv_end) ocnt <= '0;
        else if (stb)      ocnt <= ocnt + 1'b1;
    end

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stb) && (gain_div > 1)) |-> !stb); // R1
endmodule

// File: rtl/decim_chan.sv
// decim_chan: one channel's saturating ones counter and result register.
// Assumes conv_end only occurs together with stb.
module decim_chan #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             conv_end,
    input  logic             bit_in,
    output logic [CNT_W-1:0] out_word
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] sum;

    // Saturating sum of the running count and the current bit.
    always_comb begin
        if (cnt == FULL) sum = cnt;
        else             sum = cnt + CNT_W'(bit_in);
    end

    // Count on strobes, dump and clear at conversion end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            out_word <= '0;
        end else if (conv_end) begin
            out_word <= sum;
            cnt      <= '0;
        end else if (stb) begin
            cnt <= sum;
        end
    end

    AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stb) |-> $stable(cnt)); // R2
    AST_CLEAR_AFTER_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv_end) |-> (cnt == '0)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt) == FULL) && !$past(conv_end)) |-> (cnt == FULL)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(conv_end) |-> $stable(out_word)); // R5
endmodule

// File: rtl/decim_snap_xfer.sv
// decim_snap_xfer: toggle handshake that copies all results into a hold
// bank in the system domain and tells the readout domain when it is safe.
// Assumes both resets are applied together.
module decim_snap_xfer #(
    parameter int unsigned TOT_W = 256
) (
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic [TOT_W-1:0] words,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_load,
    output logic             rd_busy,
    output logic             take,
    output logic [TOT_W-1:0] hold
);
    logic req_tgl, ack_s1, ack_s2, ack_seen;
    logic req_s1, req_s2, ack_tgl;

    // Busy while the acknowledge has not come back; take on its arrival.
    always_comb begin
        rd_busy = (req_tgl != ack_seen);
        take    = (ack_s2 != ack_seen);
    end

    // Readout side: raise requests and synchronize the acknowledge.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            req_tgl  <= 1'b0;
            ack_s1   <= 1'b0;
            ack_s2   <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            ack_s1   <= ack_tgl;
            ack_s2   <= ack_s1;
            ack_seen <= ack_s2;
            if (rd_load && !rd_busy) req_tgl <= ~req_tgl;
        end
    end

    // System side: synchronize the request and capture the hold bank.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            req_s1  <= 1'b0;
            req_s2  <= 1'b0;
            ack_tgl <= 1'b0;
            hold    <= '0;
        end else begin
            req_s1 <= req_tgl;
            req_s2 <= req_s1;
            if (req_s2 != ack_tgl) begin
                hold    <= words;
                ack_tgl <= req_s2;
            end
        end
    end

    AST_REQ_ONLY_IDLE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $past(rd_busy) |-> $stable(req_tgl)); // R7
    AST_HOLD_STABLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ($past(req_s2) == $past(ack_tgl)) |-> $stable(hold)); // R6
endmodule

// File: rtl/decim_serializer.sv
// decim_serializer: 256-bit shift register loaded from the hold bank,
// presenting its top bit and shifting toward it.
module decim_serializer #(
    parameter int unsigned TOT_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [TOT_W-1:0] load_data,
    output logic             ser_out
);
    logic [TOT_W-1:0] shreg;

    // The current serial bit is the top of the register.
    always_comb ser_out = shreg[TOT_W-1];

    // Load has priority over shift; zeros fill from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= '0;
        else if (load)  shreg <= load_data;
        else if (shift) shreg <= {shreg[TOT_W-2:0], 1'b0};
    end
endmodule

// File: rtl/cnt_decim_array.sv
// cnt_decim_array: sixteen counting decimators with a shared strobe and a
// bit-serial snapshot readout on an independent clock. Channel 0 is placed
// at the top of the flattened bus so it leaves first, MSB first.
module cnt_decim_array
    import decim_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned GAIN_W = 8,
    parameter int unsigned OSR_W  = 20
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic [GAIN_W-1:0] gain_div,
    input  logic [OSR_W-1:0]  osr_len,
    input  logic [NUM_CH-1:0] mod_bits,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_load,
    input  logic              rd_shift,
    output logic              rd_busy,
    output logic              ser_out
);
    localparam int unsigned TOT_W = NUM_CH * CNT_W;

    logic             stb, conv_end, take;
    logic [TOT_W-1:0] words, hold;

    decim_timing #(.GAIN_W(GAIN_W), .OSR_W(OSR_W)) u_timing (
        .clk(sys_clk), .rst_n(sys_rst_n), .gain_div(gain_div),
        .osr_len(osr_len), .stb(stb), .conv_end(conv_end)
    );

    // One counter per channel, packed channel 0 highest.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        decim_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(sys_clk), .rst_n(sys_rst_n), .stb(stb), .conv_end(conv_end),
            .bit_in(mod_bits[ch]),
            .out_word(words[TOT_W-1-ch*CNT_W -: CNT_W])
        );
    end

    decim_snap_xfer #(.TOT_W(TOT_W)) u_xfer (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .words(words),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_load(rd_load),
        .rd_busy(rd_busy), .take(take), .hold(hold)
    );

    decim_serializer #(.TOT_W(TOT_W)) u_ser (
        .clk(rd_clk), .rst_n(rd_rst_n), .load(take), .shift(rd_shift),
        .load_data(hold), .ser_out(ser_out)
    );
endmodule

// File: tb/cnt_decim_array_bench.sv
module cnt_decim_array_bench;
    localparam int NCH = 16;
    localparam int CW  = 16;
    localparam int GW  = 8;
    localparam int OW  = 20;

    logic sys_clk = 1'b0, rd_clk = 1'b0;
    logic sys_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [NCH-1:0] mod_bits = '0;
    logic rd_load = 1'b0, rd_shift = 1'b0;
    logic rd_busy, ser_out;
    int cfg_g = 1, cfg_osr = 12, pat = 0;
    logic [GW-1:0] gain_div;
    logic [OW-1:0] osr_len;
    assign gain_div = cfg_g[GW-1:0];
    assign osr_len  = cfg_osr[OW-1:0];

    always #5   sys_clk = ~sys_clk;
    always #6.5 rd_clk  = ~rd_clk;

    cnt_decim_array u_cnt_decim_array (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .gain_div(gain_div),
        .osr_len(osr_len), .mod_bits(mod_bits), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .rd_load(rd_load), .rd_shift(rd_shift),
        .rd_busy(rd_busy), .ser_out(ser_out)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int g_ph, o_ph, conv_seen = 0;
    int mcnt[NCH], mout[NCH], expw[NCH], got[NCH];
    logic [31:0] lfsr = 32'h1ACE_5EED;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference of strobe, counting, saturation and dump.
    always @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            g_ph = 0; o_ph = 0;
            for (int c = 0; c < NCH; c++) begin mcnt[c] = 0; mout[c] = 0; end
        end else begin
            if (g_ph + 1 >= cfg_g) begin
                g_ph = 0;
                for (int c = 0; c < NCH; c++) begin
                    int v;
                    v = mcnt[c] + int'(mod_bits[c]);
                    if (v > 65535) v = 65535;
                    mcnt[c] = v;
                end
                if (o_ph + 1 >= cfg_osr) begin
                    o_ph = 0;
                    for (int c = 0; c < NCH; c++) begin mout[c] = mcnt[c]; mcnt[c] = 0; end
                    conv_seen++;
                end else o_ph++;
            end else g_ph++;
        end
    end

    // Modulator bit patterns, driven away from the sampling edge.
    always @(negedge sys_clk) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        case (pat)
            0: mod_bits = '0;
            1: mod_bits = '1;
            2: mod_bits = lfsr[15:0] ^ lfsr[31:16];
            default: mod_bits = {15'd0, 1'b1};
        endcase
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge sys_clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_reset(int g, int osr, int p);
        @(negedge sys_clk);
        cfg_g = g; cfg_osr = osr; pat = p;
        sys_rst_n = 1'b0; rd_rst_n = 1'b0;
        repeat (4) @(negedge sys_clk);
        sys_rst_n = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
    endtask

    // Snapshot right after a conversion end and shift nw words out.
    task automatic read_words(int nw, string req, bit double_load);
        int c;
        c = conv_seen;
        wait (conv_seen != c);
        @(negedge rd_clk);
        for (int k = 0; k < NCH; k++) expw[k] = mout[k];
        rd_load = 1'b1;
        @(negedge rd_clk);
        rd_load = double_load;
        check("R6 busy after load", int'(rd_busy), 1);
        @(negedge rd_clk);
        rd_load = 1'b0;
        while (rd_busy) @(negedge rd_clk);
        for (int w = 0; w < nw; w++) begin
            int acc;
            acc = 0;
            for (int b = 0; b < CW; b++) begin
                acc = (acc << 1) | int'(ser_out);
                rd_shift = 1'b1;
                @(negedge rd_clk);
            end
            got[w] = acc;
            check($sformatf("%s word ch%0d", req, w), acc, expw[w]);
        end
        rd_shift = 1'b0;
        if (nw == NCH) check("R8 stream drained", int'(ser_out), 0);
    endtask

    initial begin
        // R9: reset state and all-zero results
        do_reset(3, 12, 0);
        @(negedge rd_clk);
        check("R9 busy at reset", int'(rd_busy), 0);
        check("R9 ser_out at reset", int'(ser_out), 0);
        read_words(NCH, "R9", 1'b0);

        // R2: ones counted only on strobes, G=3, OSR=10
        do_reset(3, 10, 1);
        read_words(NCH, "R2", 1'b0);
        check("R2 ones per conversion", got[5], 10);

        // R1: gain_div 0 acts as 1
        do_reset(0, 12, 1);
        read_words(NCH, "R1", 1'b0);
        check("R1 zero period count", got[0], 12);

        // R3 / R5 / R8: random bits, mid-conversion snapshots, channel order
        do_reset(2, 16, 2);
        read_words(NCH, "R3", 1'b0);
        read_words(NCH, "R5", 1'b0);
        do_reset(1, 12, 3);
        read_words(NCH, "R8", 1'b0);
        check("R8 ch0 first", got[0], 12);
        check("R8 ch1 second", got[1], 0);

        // R7: second load while busy is ignored
        do_reset(2, 20, 2);
        read_words(NCH, "R7", 1'b1);
        repeat (10) @(negedge rd_clk);
        check("R7 no second request", int'(rd_busy), 0);

        // R10: partial read then full read restarts at channel 0
        read_words(1, "R10 partial", 1'b0);
        read_words(NCH, "R10", 1'b0);

        // R4: more than 65535 strobes of ones saturate
        do_reset(1, 66000, 1);
        read_words(NCH, "R4", 1'b0);
        check("R4 saturated value", got[15], 65535);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule